// File: doc/BRIEF.md
# Timer Prescaler with Deferred Reload

This block divides an enabled input clock by a programmable ratio and produces a single-cycle count-enable pulse for a timer counter. A bus-writable preset register sets the ratio: a stored value of N gives one pulse every N+1 enabled cycles. A value of 24, for example, gives one pulse every 25 enabled cycles.

A write to the preset never disturbs the division period that is in progress. The written value is held in the preset register. It reaches the live down-counter only when the counter underflows, or when the timer asks for a counter reload. That request can come from a software command or from an external event. The reload request works whether or not the input clock is enabled. Readback always returns the preset register and never the live count.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `tpre_top`

## Requirements
- R1: After reset, rd_data reads 0, tick is 0 and the live counter holds 0. The first enabled cycle therefore produces a tick, which gives divide-by-1.
- R2: rd_data returns the value of the most recent write. It changes one cycle after a cycle with wr_en high and holds while wr_en is low.
- R3: With preset N loaded, a cycle with clk_en high and a live count of 0 is an underflow. Tick goes high for exactly the one cycle after each underflow. Underflows recur every N+1 enabled cycles.
- R4: In cycles with clk_en low and no reload request, the live count holds. Such a cycle produces no tick.
- R5: A preset write leaves the period in progress unchanged. The new value governs counting from the next underflow or reload onward.
- R6: A cycle with reload_req high loads the live counter from the preset, whether clk_en is high or low. If the count is not 0, or clk_en is low, that cycle produces no tick.
- R7: When reload_req and an underflow fall in the same cycle, the counter loads once from the preset and exactly one tick follows.
- R8: When a write falls in the same cycle as a load (reload or underflow), the counter loads the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Input-clock enable; qualifies counting |
| wr_en | input | 1 | Preset register write strobe |
| wr_data | input | 8 | Value written to the preset register |
| rd_data | output | 8 | Preset register readback |
| reload_req | input | 1 | Counter reload request (software or external) |
| tick | output | 1 | One-cycle count-enable pulse |

## Verification
A cycle-by-cycle behavioural model predicts tick and rd_data on every clock. The model is driven with several input patterns:
- Steady division at several presets, including 0 and 255, separates the N+1 ratio from an off-by-one error.
- A gappy clk_en pattern shows that disabled cycles neither count nor tick.
- Writes in mid-period tell deferred loading apart from immediate loading.
- Reload requests cover three cases: alone with the count not 0, alone while clk_en is low, and in the same cycle as an underflow or a write. These cases separate a restart from a double tick, and a stale load value from the freshly written one.

// File: rtl/tpre_pkg.sv
package tpre_pkg;
  parameter int unsigned PRE_W = 8;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/tpre_shadow_reg.sv
module tpre_shadow_reg #(
  parameter int unsigned W = tpre_pkg::PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] load_val
);
  logic [W-1:0] preset_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     preset_q <= '0;
    else if (wr_en) preset_q <= wr_data;
  end

  assign rd_data  = preset_q;
  // A write coinciding with a load supplies the fresh value.
  assign load_val = wr_en ? wr_data : preset_q;

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/tpre_down_counter.sv
module tpre_down_counter
  import tpre_pkg::*;
#(
  parameter int unsigned W = PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic         at_zero;
  logic         underflow;
  cnt_act_e     act;

  assign at_zero   = (cnt_q == '0);
  assign underflow = clk_en && at_zero;

  always_comb begin
    if (reload || underflow) act = ACT_LOAD;
    else if (clk_en)         act = ACT_DEC;
    else                     act = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      unique case (act)
        ACT_LOAD: cnt_q <= load_val;
        ACT_DEC:  cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
      tick <= underflow;
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !reload) |=> ($stable(cnt_q) && !tick));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_reload_load: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(load_val)));
  a_r6_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && (!clk_en || cnt_q != '0)) |=> !tick);
endmodule

// File: rtl/tpre_top.sv
module tpre_top #(
  parameter int unsigned W = tpre_pkg::PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         reload_req,
  output logic         tick
);
  logic [W-1:0] load_val;

  tpre_shadow_reg #(.W(W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .load_val (load_val)
  );

  tpre_down_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .reload   (reload_req),
    .load_val (load_val),
    .tick     (tick)
  );

  a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !tick);
endmodule

// File: tb/tpre_top_bench.sv
module tpre_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       reload_req = 1'b0;
  logic [7:0] rd_data;
  logic       tick;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_cnt = 0;
  int m_pre = 0;
  int m_tick = 0;
  int tick_total = 0;

  always #5 clk = ~clk;

  tpre_top u_tpre_top (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .reload_req(reload_req), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit en, input bit we, input int wd, input bit rl);
    int lv;
    bit uf;
    clk_en = en; wr_en = we; wr_data = wd[7:0]; reload_req = rl;
    @(posedge clk);
    lv = we ? wd : m_pre;
    uf = en && (m_cnt == 0);
    m_tick = uf ? 1 : 0;
    if (rl || uf) m_cnt = lv;
    else if (en) m_cnt = m_cnt - 1;
    if (we) m_pre = wd;
    @(negedge clk);
    check(cur_req, int'(tick), m_tick, "tick");
    check(cur_req, int'(rd_data), m_pre, "rd_data");
    if (tick) tick_total++;
  endtask

  task automatic idle_en(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then divide-by-1
    check("R1", int'(rd_data), 0, "reset rd_data");
    check("R1", int'(tick), 0, "reset tick");
    cur_req = "R1";
    idle_en(4);

    // R3: divide by N+1 with a tick count check
    cur_req = "R3";
    cyc(1'b1, 1'b1, 4, 1'b0);
    idle_en(5);
    t0 = tick_total;
    idle_en(25);
    check("R3", tick_total - t0, 5, "ticks in 25 cycles at preset 4");

    // R2: readback of last write
    cur_req = "R2";
    cyc(1'b0, 1'b1, 8'hA5, 1'b0);
    cyc(1'b0, 1'b0, 0, 1'b0);
    check("R2", int'(rd_data), 8'hA5, "readback");
    cyc(1'b1, 1'b1, 2, 1'b0);

    // R4: gappy enable
    cur_req = "R4";
    for (int i = 0; i < 30; i++) cyc(i % 3 == 0, 1'b0, 0, 1'b0);

    // R5: mid-period writes deferred
    cur_req = "R5";
    cyc(1'b1, 1'b1, 9, 1'b0);
    idle_en(12);
    cyc(1'b1, 1'b1, 1, 1'b0);
    idle_en(15);

    // R6: reload with count not zero, and with enable low
    cur_req = "R6";
    cyc(1'b1, 1'b1, 6, 1'b0);
    idle_en(9);
    cyc(1'b1, 1'b0, 0, 1'b1);
    idle_en(3);
    cyc(1'b0, 1'b0, 0, 1'b1);
    idle_en(10);

    // R7: reload coinciding with underflow
    cur_req = "R7";
    cyc(1'b1, 1'b1, 3, 1'b1);
    idle_en(3);
    cyc(1'b1, 1'b0, 0, 1'b1);
    check("R7", int'(tick), 1, "single tick");
    cyc(1'b1, 1'b0, 0, 1'b0);
    check("R7", int'(tick), 0, "no second tick");
    idle_en(6);

    // R8: write coincides with reload and with underflow
    cur_req = "R8";
    cyc(1'b1, 1'b1, 7, 1'b1);
    idle_en(3);
    cyc(1'b1, 1'b1, 2, 1'b1);
    idle_en(7);
    cyc(1'b1, 1'b1, 5, 1'b0);
    idle_en(1);
    cyc(1'b1, 1'b1, 0, 1'b0);
    idle_en(12);

    // R3: extreme presets
    cur_req = "R3";
    cyc(1'b1, 1'b1, 255, 1'b1);
    t0 = tick_total;
    idle_en(512);
    check("R3", tick_total - t0, 2, "ticks in 512 cycles at preset 255");
    cyc(1'b1, 1'b1, 0, 1'b1);
    idle_en(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule